// File: doc/BRIEF.md
# Masked Condition Field Logic Unit

This unit carries out two bitwise lookup operations on a 32-bit condition register that is split into eight 4-bit fields. Each operation names a destination field and two source fields. The destination field is also the first operand. The three-operand form looks up an 8-entry table held in the instruction word. The two-operand form looks up a 4-entry table taken from the third field named. A 4-bit per-bit mask limits the write: destination bits whose mask bit is clear keep their old value. An all-zero mask, or a word that matches neither operation, is flagged as illegal, and the register then comes back unchanged.

One request is one instruction word plus the current register value, sent on a valid/ready input channel. One response is the updated register plus an illegal flag, returned on a valid/ready output channel. The unit holds one result in a single output register. It accepts a new request when that register is empty, or in the same cycle the register is being drained (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the response stays frozen and no input is taken. Every accepted request produces exactly one response, and responses leave in the order the requests arrived.

Top module: `cfl_unit`

## Requirements
- R1: Bit positions are MSB-first, and bit k of a 32-bit word is `w[31-k]`. Field n, bit i (i = 0..3) is register bit 4n+i. The result differs from the input register only inside the destination field.
- R2: Three-operand form: major opcode `PO` in word bits 0-5 and sub-opcode `XO_TERN` in bits 26-30. Destination is bits 6-8, first source is bits 11-13, second source is bits 16-18. For each bit i, j = {dest[i], src1[i], src2[i]}, with dest as the MSB. Table entry j is word bit 19+j for j < 7, and word bit 31 for j = 7. That entry becomes the new dest[i].
- R3: Two-operand form (sub-opcode `XO_BIN`): j = {dest[i], src1[i]}, and the new dest[i] is bit j of the second-source field.
- R4: Mask bits 0-1 are word bits 9-10 and mask bits 2-3 are word bits 14-15. Mask bit i enables the write of dest[i]. A clear mask bit leaves that destination bit unchanged.
- R5: An all-zero mask in either form sets `illegal` and returns the register unchanged.
- R6: When the destination equals one or both sources, every operand is taken from the register value before the update.
- R7: The two-operand form ignores word bits 19-25 and bit 31.
- R8: A word whose major opcode or sub-opcode matches neither form sets `illegal` and returns the register unchanged.
- R9: Responses come out in request order, one per accepted request. A response stays stable while it is stalled, and `in_ready` follows the rule given above.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A request is presented |
| in_ready | output | 1 | The unit can take a request this cycle |
| in_instr | input | 32 | Instruction word |
| in_cr | input | 32 | Current condition register value |
| out_valid | output | 1 | A response is presented |
| out_ready | input | 1 | The consumer takes the response this cycle |
| out_cr | output | 32 | Updated condition register |
| out_illegal | output | 1 | The instruction was illegal and the register is unchanged |

## Verification
The tables are chosen to separate behaviours. An all-zeros table and an all-ones table expose a stuck lookup. A parity table (0x96) and a single-entry table catch a reversed index order or a swapped operand. Masks with alternating bits show whether the mask halves were taken from the right word positions. Aliased fields, fields 0 and 7 as the destination, reserved bits set in the two-operand form, and wrong major opcodes or sub-opcodes test the ordering and decode corners. A long run of random words under random output stalls checks ordering and response stability against a scoreboard.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  localparam int FIELD_W    = 4;
  localparam int NUM_FIELDS = 8;
  localparam int CR_W       = FIELD_W * NUM_FIELDS;
  localparam int SEL_W      = $clog2(NUM_FIELDS);
  localparam int TBL_W      = 8;
  localparam int IDX3_W     = $clog2(TBL_W);
  localparam int IDX2_W     = $clog2(FIELD_W);
  localparam int INSTR_W    = 32;
  localparam int OP_W       = 6;
  localparam int XO_W       = 5;

  typedef enum logic [1:0] {OP_NONE, OP_TERN, OP_BIN} cfl_op_e;

  // msk[i] and tbl[j] are indexed by the MSB-first element number
  typedef struct packed {
    cfl_op_e              op;
    logic [SEL_W-1:0]     dst;
    logic [SEL_W-1:0]     src1;
    logic [SEL_W-1:0]     src2;
    logic [FIELD_W-1:0]   msk;
    logic [TBL_W-1:0]     tbl;
    logic                 illegal;
  } cfl_dec_t;
endpackage

// File: rtl/cfl_decode.sv
module cfl_decode
  import cfl_pkg::*;
#(
  parameter logic [OP_W-1:0] PO      = 6'd19,
  parameter logic [XO_W-1:0] XO_TERN = 5'd8,
  parameter logic [XO_W-1:0] XO_BIN  = 5'd9
) (
  input  logic [INSTR_W-1:0] instr,
  output cfl_dec_t           dec
);
  localparam int TOP = INSTR_W - 1;

  logic [OP_W-1:0] po;
  logic [XO_W-1:0] xo;

  always_comb begin
    po       = instr[TOP -: OP_W];
    xo       = instr[5:1];
    dec.dst  = instr[TOP-6  -: SEL_W];
    dec.src1 = instr[TOP-11 -: SEL_W];
    dec.src2 = instr[TOP-16 -: SEL_W];
    dec.msk[0] = instr[TOP-9];
    dec.msk[1] = instr[TOP-10];
    dec.msk[2] = instr[TOP-14];
    dec.msk[3] = instr[TOP-15];
    for (int j = 0; j < TBL_W - 1; j++) dec.tbl[j] = instr[TOP-19-j];
    dec.tbl[TBL_W-1] = instr[0];
    if (po == PO && xo == XO_TERN)     dec.op = OP_TERN;
    else if (po == PO && xo == XO_BIN) dec.op = OP_BIN;
    else                               dec.op = OP_NONE;
    dec.illegal = (dec.op == OP_NONE) || (dec.msk == '0);
  end
endmodule

// File: rtl/cfl_field_read.sv
module cfl_field_read
  import cfl_pkg::*;
(
  input  logic [CR_W-1:0]    cr,
  input  logic [SEL_W-1:0]   sel,
  output logic [FIELD_W-1:0] fld   // fld[i] = MSB-first bit i of the field
);
  always_comb begin
    fld = '0;
    for (int n = 0; n < NUM_FIELDS; n++) begin
      if (sel == SEL_W'(n)) begin
        for (int i = 0; i < FIELD_W; i++) fld[i] = cr[CR_W-1-FIELD_W*n-i];
      end
    end
  end
endmodule

// File: rtl/cfl_lut_core.sv
module cfl_lut_core
  import cfl_pkg::*;
(
  input  cfl_op_e            op,
  input  logic [FIELD_W-1:0] a,
  input  logic [FIELD_W-1:0] b,
  input  logic [FIELD_W-1:0] c,
  input  logic [TBL_W-1:0]   tbl,
  input  logic [FIELD_W-1:0] msk,
  output logic [FIELD_W-1:0] res
);
  genvar gi;
  generate
    for (gi = 0; gi < FIELD_W; gi++) begin : g_bit
      logic [IDX3_W-1:0] j3;
      logic [IDX2_W-1:0] j2;
      logic              val;
      always_comb begin
        j3  = {a[gi], b[gi], c[gi]};
        j2  = {a[gi], b[gi]};
        val = (op == OP_BIN) ? c[j2] : tbl[j3];
        res[gi] = msk[gi] ? val : a[gi];
      end
    end
  endgenerate

  // R4: bits with a clear mask keep the destination value
  always_comb begin
    if (op != OP_NONE)
      p_unmasked_kept_r4: assert (((res ^ a) & ~msk) == '0)
        else $error("unmasked destination bit changed");
  end
endmodule

// File: rtl/cfl_unit.sv
module cfl_unit
  import cfl_pkg::*;
#(
  parameter logic [OP_W-1:0] PO      = 6'd19,
  parameter logic [XO_W-1:0] XO_TERN = 5'd8,
  parameter logic [XO_W-1:0] XO_BIN  = 5'd9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [CR_W-1:0]   in_cr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CR_W-1:0]   out_cr,
  output logic              out_illegal
);
  cfl_dec_t           dec;
  logic [FIELD_W-1:0] fa, fb, fc, fnew;
  logic [CR_W-1:0]    next_cr;
  logic               in_fire;

  cfl_decode #(.PO(PO), .XO_TERN(XO_TERN), .XO_BIN(XO_BIN)) u_dec (
    .instr(in_instr), .dec(dec));

  cfl_field_read u_rd_dst  (.cr(in_cr), .sel(dec.dst),  .fld(fa));
  cfl_field_read u_rd_src1 (.cr(in_cr), .sel(dec.src1), .fld(fb));
  cfl_field_read u_rd_src2 (.cr(in_cr), .sel(dec.src2), .fld(fc));

  cfl_lut_core u_core (
    .op(dec.op), .a(fa), .b(fb), .c(fc), .tbl(dec.tbl), .msk(dec.msk), .res(fnew));

  // all operands come from in_cr, so aliased fields see the old value
  always_comb begin
    next_cr = in_cr;
    if (!dec.illegal) begin
      for (int n = 0; n < NUM_FIELDS; n++) begin
        if (dec.dst == SEL_W'(n)) begin
          for (int i = 0; i < FIELD_W; i++) next_cr[CR_W-1-FIELD_W*n-i] = fnew[i];
        end
      end
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_cr      <= '0;
      out_illegal <= 1'b0;
    end else begin
      if (in_fire) begin
        out_valid   <= 1'b1;
        out_cr      <= next_cr;
        out_illegal <= dec.illegal;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

  // R1: only the destination field may differ from the input register
  always_comb begin
    if (rst_n && in_valid && !dec.illegal) begin
      for (int n = 0; n < NUM_FIELDS; n++) begin
        if (dec.dst != SEL_W'(n))
          p_other_fields_kept_r1: assert (next_cr[CR_W-1-FIELD_W*n -: FIELD_W] ==
                                           in_cr[CR_W-1-FIELD_W*n -: FIELD_W])
            else $error("non-destination field changed");
      end
    end
  end

  // R5 / R8: an illegal request returns the register untouched
  always_comb begin
    if (rst_n && in_valid && dec.illegal)
      p_illegal_unchanged_r5: assert (next_cr == in_cr)
        else $error("illegal request altered the register");
  end

  // R9: a stalled response holds
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cr) && $stable(out_illegal))
    else $error("stalled response changed");
endmodule

// File: tb/cfl_unit_bench.sv
module cfl_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] PO = 6'd19;
  localparam logic [4:0] XT = 5'd8;
  localparam logic [4:0] XB = 5'd9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [31:0] in_instr = '0, in_cr = '0;
  logic out_valid, out_ready = 1'b0, out_illegal;
  logic [31:0] out_cr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfl_unit u_cfl_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_cr(in_cr), .out_valid(out_valid),
    .out_ready(out_ready), .out_cr(out_cr), .out_illegal(out_illegal));

  typedef struct { logic [31:0] cr; logic ill; string tag; } exp_t;
  exp_t sb[$];
  int tests = 0, fails = 0;
  bit done = 0, stall_en = 0;

  function automatic logic gb(logic [31:0] w, int k); return w[31-k]; endfunction

  function automatic logic [31:0] mk(logic [5:0] po, int dst, logic [3:0] m,
      int s1, int s2, logic [7:0] t, logic [4:0] xo);
    logic [31:0] w = '0;
    for (int k = 0; k < 6; k++) w[31-k] = po[5-k];
    for (int k = 0; k < 3; k++) begin
      w[31-(6+k)]  = dst[2-k];
      w[31-(11+k)] = s1[2-k];
      w[31-(16+k)] = s2[2-k];
    end
    w[31-9] = m[0]; w[31-10] = m[1]; w[31-14] = m[2]; w[31-15] = m[3];
    for (int j = 0; j < 7; j++) w[31-(19+j)] = t[j];
    w[0] = t[7];
    for (int k = 0; k < 5; k++) w[31-(26+k)] = xo[4-k];
    return w;
  endfunction

  function automatic exp_t model(logic [31:0] w, logic [31:0] cr, string tag);
    exp_t e;
    int d, a, b, j;
    logic [5:0] po; logic [4:0] xo; logic [3:0] m;
    logic [3:0] fd, fa, fb;
    bit tern, bin;
    for (int k = 0; k < 6; k++) po[5-k] = gb(w, k);
    for (int k = 0; k < 5; k++) xo[4-k] = gb(w, 26+k);
    d = 4*gb(w,6) + 2*gb(w,7) + gb(w,8);
    a = 4*gb(w,11) + 2*gb(w,12) + gb(w,13);
    b = 4*gb(w,16) + 2*gb(w,17) + gb(w,18);
    m[0] = gb(w,9); m[1] = gb(w,10); m[2] = gb(w,14); m[3] = gb(w,15);
    tern = (po == PO) && (xo == XT);
    bin  = (po == PO) && (xo == XB);
    e.cr = cr; e.tag = tag;
    e.ill = !(tern || bin) || (m == 4'd0);
    if (!e.ill) begin
      for (int i = 0; i < 4; i++) begin
        fd[i] = gb(cr, 4*d+i); fa[i] = gb(cr, 4*a+i); fb[i] = gb(cr, 4*b+i);
      end
      for (int i = 0; i < 4; i++) begin
        if (m[i]) begin
          if (tern) begin
            j = 4*fd[i] + 2*fa[i] + fb[i];
            e.cr[31-(4*d+i)] = (j < 7) ? gb(w, 19+j) : gb(w, 31);
          end else begin
            j = 2*fd[i] + fa[i];
            e.cr[31-(4*d+i)] = fb[j];
          end
        end
      end
    end
    return e;
  endfunction

  task automatic send(logic [31:0] w, logic [31:0] cr, string tag);
    sb.push_back(model(w, cr, tag));
    @(negedge clk);
    in_valid = 1'b1; in_instr = w; in_cr = cr;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // monitor: out_ready changes at negedge; a transfer is compared before its edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      out_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
      #2;
      if (rst_n && out_valid && out_ready) begin
        tests++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R9 unexpected response cr=%h ill=%0b expected none", out_cr, out_illegal);
        end else begin
          e = sb.pop_front();
          if (out_cr !== e.cr || out_illegal !== e.ill) begin
            fails++;
            $display("FAIL %s cr=%h ill=%0b expected cr=%h ill=%0b",
                     e.tag, out_cr, out_illegal, e.cr, e.ill);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired, actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] crv, w;
    repeat (3) @(posedge clk);
    #1;
    tests++;  // R10
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end
    @(negedge clk); rst_n = 1'b1;
    crv = 32'h5A3C_96F1;
    send(mk(PO, 2, 4'hF, 5, 7, 8'h96, XT), crv, "R2 parity table");
    send(mk(PO, 3, 4'hF, 1, 6, 8'h00, XT), crv, "R2 zero table");
    send(mk(PO, 4, 4'hF, 0, 2, 8'hFF, XT), crv, "R2 ones table");
    send(mk(PO, 1, 4'hF, 6, 3, 8'h80, XT), 32'hFFFF_0F0F, "R2 single entry");
    send(mk(PO, 5, 4'hF, 2, 6, 8'h00, XB), crv, "R3 binary table");
    send(mk(PO, 6, 4'hF, 4, 1, 8'h00, XB), 32'h1234_ABCD, "R3 binary table b");
    send(mk(PO, 2, 4'b0101, 5, 7, 8'h69, XT), crv, "R4 mask 0101");
    send(mk(PO, 2, 4'b1010, 5, 7, 8'h69, XT), crv, "R4 mask 1010");
    send(mk(PO, 5, 4'b1100, 2, 6, 8'h00, XB), crv, "R4 binary mask");
    send(mk(PO, 2, 4'h0, 5, 7, 8'hFF, XT), crv, "R5 zero mask ternary");
    send(mk(PO, 2, 4'h0, 5, 7, 8'hFF, XB), crv, "R5 zero mask binary");
    send(mk(PO, 3, 4'hF, 3, 3, 8'hE8, XT), crv, "R6 full alias ternary");
    send(mk(PO, 3, 4'hF, 3, 0, 8'h00, XB), crv, "R6 alias binary");
    send(mk(PO, 4, 4'hF, 1, 4, 8'h00, XB), 32'h0F3C_A596, "R6 dest equals table");
    send(mk(PO, 5, 4'hF, 2, 6, 8'hFF, XB), crv, "R7 reserved bits set");
    send(mk(PO, 0, 4'hF, 7, 3, 8'h1E, XT), crv, "R1 field 0");
    send(mk(PO, 7, 4'hF, 0, 3, 8'h1E, XT), crv, "R1 field 7");
    send(mk(6'd20, 2, 4'hF, 5, 7, 8'h96, XT), crv, "R8 wrong major opcode");
    send(mk(PO, 2, 4'hF, 5, 7, 8'h96, 5'd10), crv, "R8 wrong sub-opcode");
    stall_en = 1;
    for (int n = 0; n < 400; n++) begin
      crv = $urandom;
      w = mk(PO, $urandom_range(0, 7), 4'($urandom_range(0, 15)),
             $urandom_range(0, 7), $urandom_range(0, 7), 8'($urandom),
             ($urandom_range(0, 1) != 0) ? XT : XB);
      if (n % 10 == 9) w = $urandom;
      send(w, crv, "R9 random stream");
      if (n % 7 == 0) repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    while (sb.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule